// File: doc/BRIEF.md
# Multi-format TDM audio serial port

This block is a slave-side audio serial port. An external bit clock and frame clock set the timing. The block takes in six playback channels and sends out four capture channels. Every sample is a 24-bit two's-complement word, and every word travels MSB first.

Both clocks arrive as plain inputs. They are synchronised into the system clock and edge-detected there. The port moves input bits on bit-clock rising edges and updates its output bits on falling edges. A format select picks one of four framings:

- right-justified 20-bit playback
- right-justified 24-bit playback
- left-justified
- I2S

A separate arrangement select chooses between stereo-per-line operation and two TDM frame lengths. Each arrangement places the channels on the serial lines in its own way. Playback words appear on a parallel bus, and a one-cycle strobe marks each finished frame. Capture words are read from a parallel input bus.

Top module: `aud_tdm_port`

## Requirements
- R1: While reset is held and after it is released, the playback bus is all zero, the frame strobe is low and both capture lines are low until the first frame start.
- R2: Arrangement code 00 (and unused code 10) is stereo-per-line: a frame is 64 bit clocks split into two 32-clock slots, left then right. Playback line n (n = 0..2) carries channels 2n and 2n+1. Capture line m (m = 0..1) carries capture channels 2m and 2m+1. Channel order is L1, R1, L2, R2, L3, R3.
- R3: Format code 0 takes playback as 20-bit right-justified. The word occupies slot bits 12..31, and the four low bits of the 24-bit result are zero.
- R4: Format code 1 takes playback as 24-bit right-justified, occupying slot bits 8..31.
- R5: Format code 2 takes playback left-justified (MSB at slot bit 0). Format codes 0, 1 and 2 send capture left-justified. In all three, the frame starts on the frame-clock rising edge, and the frame clock is high for the left slot.
- R6: Format code 3 (I2S) starts the frame on the frame-clock falling edge, with the clock low for the left slot. The MSB sits at slot bit 1 in both directions.
- R7: Arrangement code 01 uses a 256-clock frame of eight 32-clock slots. Playback line 0 carries channels 0..5 in slots 0..5. Capture line 0 carries capture channels 0..3 in slots 0..3. Capture line 1 stays low.
- R8: Arrangement code 11 uses a 128-clock frame of four slots. Playback line 0 carries channels 0..3 in slots 0..3, and playback line 1 carries channels 4 and 5 in slots 0..1. Capture follows R7, and capture line 1 stays low.
- R9: In both TDM arrangements, a frame clock that is active for only one bit-clock period starts a frame correctly.
- R10: A completed frame raises the frame strobe for exactly one system-clock cycle, once per frame, after the frame's last bit.
- R11: Capture line levels change only after a bit-clock falling edge. The playback bus and the strobe change only after a bit-clock rising edge.
- R12: Capture words are latched at frame start. Capture bits outside a word's 24-bit window, and slots with no assigned channel, are driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | External bit clock |
| lrck_i | input | 1 | External frame clock |
| sdin_i | input | 3 | Playback serial lines |
| fmt_i | input | 2 | Format select (0 RJ20, 1 RJ24, 2 LJ, 3 I2S) |
| tdm_i | input | 2 | Arrangement select (00/10 stereo, 01 TDM256, 11 TDM128) |
| cap_data_i | input | 4x24 | Capture words, channel 0 in the low element |
| sdout_o | output | 2 | Capture serial lines |
| pb_data_o | output | 6x24 | Playback words, channel 0 in the low element |
| pb_valid_o | output | 1 | One-cycle strobe at the end of each frame |

## Verification
Each bit-clock edge passes through two synchroniser flops and one edge register, so every result appears at the third system-clock edge after the input changes:

- a capture line level appears three edges after a falling edge;
- playback words and the frame strobe appear three edges after the rising edge that ends a slot or frame.

The bench holds each bit-clock phase for eight system clocks and samples the capture lines at the end of the low phase. It samples them again at the end of the high phase to confirm they did not move on the rising edge. It reads the playback bus and the strobe count one half bit period after the last rising edge of a frame, by which time all of them are due.

// File: rtl/aud_tdm_pkg.sv
package aud_tdm_pkg;
  localparam int unsigned PB_LINES  = 3;
  localparam int unsigned CAP_LINES = 2;
  localparam int unsigned PB_CH     = 6;
  localparam int unsigned CAP_CH    = 4;
  localparam int unsigned WIDE_SLOTS   = 8;
  localparam int unsigned NARROW_SLOTS = 4;
  localparam int unsigned STEREO_SLOTS = 2;

  localparam logic [1:0] FMT_RJ_SHORT = 2'd0;
  localparam logic [1:0] FMT_RJ_FULL  = 2'd1;
  localparam logic [1:0] FMT_LJ       = 2'd2;
  localparam logic [1:0] FMT_I2S      = 2'd3;

  localparam logic [1:0] ARR_WIDE   = 2'b01;
  localparam logic [1:0] ARR_NARROW = 2'b11;

  function automatic int frame_bits(logic [1:0] arr, int slot_bits);
    if (arr == ARR_WIDE)   return slot_bits * WIDE_SLOTS;
    if (arr == ARR_NARROW) return slot_bits * NARROW_SLOTS;
    return slot_bits * STEREO_SLOTS;
  endfunction

  function automatic int rx_offset(logic [1:0] fmt, int slot_bits, int full_w, int short_w);
    case (fmt)
      FMT_RJ_SHORT: return slot_bits - short_w;
      FMT_RJ_FULL:  return slot_bits - full_w;
      FMT_LJ:       return 0;
      default:      return 1;
    endcase
  endfunction

  function automatic int rx_len(logic [1:0] fmt, int full_w, int short_w);
    return (fmt == FMT_RJ_SHORT) ? short_w : full_w;
  endfunction

  // playback line/slot -> channel, -1 when unused
  function automatic int rx_chan(logic [1:0] arr, int line, int slot);
    if (arr == ARR_WIDE)
      return (line == 0 && slot < int'(PB_CH)) ? slot : -1;
    if (arr == ARR_NARROW) begin
      if (line == 0 && slot < int'(NARROW_SLOTS)) return slot;
      if (line == 1 && slot < int'(PB_CH - NARROW_SLOTS)) return int'(NARROW_SLOTS) + slot;
      return -1;
    end
    return (slot < int'(STEREO_SLOTS)) ? int'(STEREO_SLOTS) * line + slot : -1;
  endfunction

  // capture line/slot -> channel, -1 when unused
  function automatic int tx_chan(logic [1:0] arr, int line, int slot);
    if (arr[0])
      return (line == 0 && slot < int'(CAP_CH)) ? slot : -1;
    return (slot < int'(STEREO_SLOTS)) ? int'(STEREO_SLOTS) * line + slot : -1;
  endfunction
endpackage

// File: rtl/aud_tdm_sync.sv
module aud_tdm_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/aud_tdm_frame.sv
module aud_tdm_frame
  import aud_tdm_pkg::*;
#(
  parameter int unsigned SLOT_BITS = 32,
  parameter int unsigned PW        = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic          lrck_i,
  input  logic [1:0]    fmt_i,
  input  logic [1:0]    tdm_i,
  output logic [PW-1:0] pos_o,
  output logic          ok_o,
  output logic          last_o
);
  logic [PW-1:0] pos_q;
  logic          lrck_q, seen_q, locked_q;
  logic          act_lvl, start;

  // frame opens when lrck reaches its active level
  assign act_lvl = (fmt_i != FMT_I2S);
  assign start   = seen_q && (lrck_i == act_lvl) && (lrck_q != act_lvl);
  assign pos_o   = start ? '0 : pos_q + PW'(1);
  assign ok_o    = locked_q | start;
  assign last_o  = int'(pos_o) == frame_bits(tdm_i, int'(SLOT_BITS)) - 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '1;
      lrck_q   <= 1'b0;
      seen_q   <= 1'b0;
      locked_q <= 1'b0;
    end else if (rise_i) begin
      lrck_q <= lrck_i;
      seen_q <= 1'b1;
      pos_q  <= pos_o;
      if (start) locked_q <= 1'b1;
    end
  end
endmodule

// File: rtl/aud_tdm_rx.sv
module aud_tdm_rx
  import aud_tdm_pkg::*;
#(
  parameter int unsigned SAMPLE_W  = 24,
  parameter int unsigned SHORT_W   = 20,
  parameter int unsigned SLOT_BITS = 32,
  parameter int unsigned PW        = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          rise_i,
  input  logic                          ok_i,
  input  logic                          last_i,
  input  logic [PW-1:0]                 pos_i,
  input  logic [PB_LINES-1:0]           sdin_i,
  input  logic [1:0]                    fmt_i,
  input  logic [1:0]                    tdm_i,
  output logic [PB_CH-1:0][SAMPLE_W-1:0] data_o,
  output logic                          valid_o
);
  localparam int unsigned BW = $clog2(SLOT_BITS);

  logic [BW-1:0]    bit_w;
  logic [PW-BW-1:0] slot;
  int               idx;
  logic             in_win;
  int               dest [PB_LINES];

  logic [PB_LINES-1:0][SAMPLE_W-1:0] asm_q, asm_d;
  logic [PB_CH-1:0][SAMPLE_W-1:0]    data_q;
  logic                              valid_q;

  assign bit_w = pos_i[BW-1:0];
  assign slot  = pos_i[PW-1:BW];

  always_comb begin
    idx    = int'(bit_w) - rx_offset(fmt_i, int'(SLOT_BITS), int'(SAMPLE_W), int'(SHORT_W));
    in_win = (idx >= 0) && (idx < rx_len(fmt_i, int'(SAMPLE_W), int'(SHORT_W)));
    for (int l = 0; l < int'(PB_LINES); l++) begin
      // word cleared at slot start so short formats leave zero LSBs
      asm_d[l] = (bit_w == '0) ? '0 : asm_q[l];
      if (in_win && sdin_i[l])
        asm_d[l] = asm_d[l] | (SAMPLE_W'(1) << (int'(SAMPLE_W) - 1 - idx));
      dest[l] = rx_chan(tdm_i, l, int'(slot));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asm_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rise_i && ok_i && last_i;
      if (rise_i && ok_i) begin
        asm_q <= asm_d;
        if (bit_w == BW'(SLOT_BITS - 1)) begin
          for (int l = 0; l < int'(PB_LINES); l++)
            for (int c = 0; c < int'(PB_CH); c++)
              if (dest[l] == c) data_q[c] <= asm_d[l];
        end
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/aud_tdm_tx.sv
module aud_tdm_tx
  import aud_tdm_pkg::*;
#(
  parameter int unsigned SAMPLE_W  = 24,
  parameter int unsigned SLOT_BITS = 32,
  parameter int unsigned PW        = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            fall_i,
  input  logic                            ok_i,
  input  logic [PW-1:0]                   pos_i,
  input  logic [1:0]                      fmt_i,
  input  logic [1:0]                      tdm_i,
  input  logic [CAP_CH-1:0][SAMPLE_W-1:0] cap_i,
  output logic [CAP_LINES-1:0]            sdout_o
);
  localparam int unsigned BW = $clog2(SLOT_BITS);

  logic [BW-1:0]    bit_w;
  logic [PW-BW-1:0] slot;
  int               idx, sh, ch;
  logic             in_win;
  logic [SAMPLE_W-1:0] word, shifted;

  logic [CAP_CH-1:0][SAMPLE_W-1:0] shadow_q, src;
  logic [CAP_LINES-1:0]            bit_d, sdout_q;

  assign bit_w = pos_i[BW-1:0];
  assign slot  = pos_i[PW-1:BW];
  // first bit of a frame reads the live input, the rest the latched copy
  assign src   = (pos_i == '0) ? cap_i : shadow_q;

  always_comb begin
    idx     = int'(bit_w) - ((fmt_i == FMT_I2S) ? 1 : 0);
    in_win  = (idx >= 0) && (idx < int'(SAMPLE_W));
    sh      = in_win ? int'(SAMPLE_W) - 1 - idx : 0;
    word    = '0;
    shifted = '0;
    ch      = -1;
    for (int o = 0; o < int'(CAP_LINES); o++) begin
      ch   = tx_chan(tdm_i, o, int'(slot));
      word = '0;
      for (int c = 0; c < int'(CAP_CH); c++)
        if (ch == c) word = src[c];
      shifted  = word >> sh;
      bit_d[o] = in_win && shifted[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      sdout_q  <= '0;
    end else if (fall_i) begin
      sdout_q <= ok_i ? bit_d : '0;
      if (ok_i && pos_i == '0) shadow_q <= cap_i;
    end
  end

  assign sdout_o = sdout_q;
endmodule

// File: rtl/aud_tdm_port.sv
module aud_tdm_port
  import aud_tdm_pkg::*;
#(
  parameter int unsigned SAMPLE_W  = 24,
  parameter int unsigned SHORT_W   = 20,
  parameter int unsigned SLOT_BITS = 32,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            bclk_i,
  input  logic                            lrck_i,
  input  logic [PB_LINES-1:0]             sdin_i,
  input  logic [1:0]                      fmt_i,
  input  logic [1:0]                      tdm_i,
  input  logic [CAP_CH-1:0][SAMPLE_W-1:0] cap_data_i,
  output logic [CAP_LINES-1:0]            sdout_o,
  output logic [PB_CH-1:0][SAMPLE_W-1:0]  pb_data_o,
  output logic                            pb_valid_o
);
  localparam int unsigned PW = $clog2(SLOT_BITS * WIDE_SLOTS);
  localparam int unsigned SW = PB_LINES + 2;

  logic [SW-1:0] sync_q;
  logic          bclk_d;
  logic          bclk_rise, bclk_fall;
  logic [PW-1:0] pos;
  logic          frame_ok, frame_last;

  aud_tdm_sync #(.W(SW), .STAGES(SYNC_LEN)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdin_i, lrck_i, bclk_i}),
    .q_o   (sync_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_d <= 1'b0;
    else         bclk_d <= sync_q[0];
  end

  assign bclk_rise = sync_q[0] & ~bclk_d;
  assign bclk_fall = ~sync_q[0] & bclk_d;

  aud_tdm_frame #(.SLOT_BITS(SLOT_BITS), .PW(PW)) frame_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rise_i(bclk_rise),
    .lrck_i(sync_q[1]),
    .fmt_i (fmt_i),
    .tdm_i (tdm_i),
    .pos_o (pos),
    .ok_o  (frame_ok),
    .last_o(frame_last)
  );

  aud_tdm_rx #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W), .SLOT_BITS(SLOT_BITS), .PW(PW)) rx_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (bclk_rise),
    .ok_i   (frame_ok),
    .last_i (frame_last),
    .pos_i  (pos),
    .sdin_i (sync_q[SW-1:2]),
    .fmt_i  (fmt_i),
    .tdm_i  (tdm_i),
    .data_o (pb_data_o),
    .valid_o(pb_valid_o)
  );

  aud_tdm_tx #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS), .PW(PW)) tx_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fall_i (bclk_fall),
    .ok_i   (frame_ok),
    .pos_i  (pos),
    .fmt_i  (fmt_i),
    .tdm_i  (tdm_i),
    .cap_i  (cap_data_i),
    .sdout_o(sdout_o)
  );
endmodule

// File: rtl/aud_tdm_port_chk.sv
module aud_tdm_port_chk #(
  parameter int unsigned SAMPLE_W  = 24,
  parameter int unsigned PB_CH     = 6,
  parameter int unsigned CAP_LINES = 2
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [1:0]                     tdm_i,
  input logic [CAP_LINES-1:0]           sdout_o,
  input logic [PB_CH-1:0][SAMPLE_W-1:0] pb_data_o,
  input logic                           pb_valid_o,
  input logic                           bclk_rise,
  input logic                           bclk_fall
);
  assert_strobe_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_valid_o |=> !pb_valid_o);

  assert_strobe_after_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_valid_o |-> $past(bclk_rise));

  assert_tx_on_fall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdout_o) |-> $past(bclk_fall));

  assert_rx_on_rise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pb_data_o) |-> $past(bclk_rise));

  // also covers R8
  assert_line1_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(bclk_fall) && $past(tdm_i[0])) |-> !sdout_o[1]);
endmodule

bind aud_tdm_port aud_tdm_port_chk #(
  .SAMPLE_W (SAMPLE_W),
  .PB_CH    (aud_tdm_pkg::PB_CH),
  .CAP_LINES(aud_tdm_pkg::CAP_LINES)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tdm_i     (tdm_i),
  .sdout_o   (sdout_o),
  .pb_data_o (pb_data_o),
  .pb_valid_o(pb_valid_o),
  .bclk_rise (bclk_rise),
  .bclk_fall (bclk_fall)
);

// File: tb/aud_tdm_port_tb.sv
module aud_tdm_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BCLK  = 8;
  localparam int WD_CYCLES  = 180000;

  logic clk = 1'b0;
  logic rst_n;
  logic bclk, lrck;
  logic [2:0] sdin;
  logic [1:0] fmt, tdm;
  logic [3:0][23:0] cap;
  logic [1:0] sdout;
  logic [5:0][23:0] pb;
  logic pb_valid;

  int total = 0;
  int bad = 0;
  int vcnt = 0;
  bit done = 0;

  logic [23:0] pbv [6];
  logic [23:0] capv [4];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (pb_valid) vcnt++;

  aud_tdm_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .lrck_i(lrck), .sdin_i(sdin),
    .fmt_i(fmt), .tdm_i(tdm), .cap_data_i(cap), .sdout_o(sdout),
    .pb_data_o(pb), .pb_valid_o(pb_valid)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (HALF_BCLK) @(negedge clk);
  endtask

  function automatic int map_rx(logic [1:0] t, int l, int s);
    if (t == 2'b01) return (l == 0 && s < 6) ? s : -1;
    if (t == 2'b11) begin
      if (l == 0 && s < 4) return s;
      if (l == 1 && s < 2) return 4 + s;
      return -1;
    end
    return (s < 2) ? 2 * l + s : -1;
  endfunction

  function automatic int map_tx(logic [1:0] t, int o, int s);
    if (t[0]) return (o == 0 && s < 4) ? s : -1;
    return (s < 2) ? 2 * o + s : -1;
  endfunction

  function automatic logic [23:0] pat(int k, int c);
    logic [31:0] x;
    if (k % 3 == 0) begin
      case (c % 6)
        0: return 24'h800000;
        1: return 24'h7FFFFF;
        2: return 24'hFFFFFF;
        3: return 24'h000001;
        4: return 24'hA5A5A5;
        default: return 24'h5A5A5A;
      endcase
    end
    x = 32'(k * 10 + c + 1) * 32'h9E3779B1;
    return x[31:8];
  endfunction

  function automatic string pb_tag(logic [1:0] t, logic [1:0] f, int hi);
    if (t == 2'b01) return (hi == 1) ? "R7 R9" : "R7";
    if (t == 2'b11) return (hi == 1) ? "R8 R9" : "R8";
    case (f)
      2'd0: return "R2 R3";
      2'd1: return "R2 R4";
      2'd2: return "R2 R5";
      default: return "R2 R6";
    endcase
  endfunction

  task automatic run_frame(logic [1:0] t, logic [1:0] f, int k, int j);
    int n, hi, off, len, coff, zbad, sbad, ch, slot, b;
    logic act;
    logic [23:0] got [4];
    logic [23:0] word, expv;
    logic [1:0] s0;
    n    = (t == 2'b01) ? 256 : (t == 2'b11) ? 128 : 64;
    hi   = (t[0] && j == 0) ? 1 : n / 2;
    act  = (f != 2'd3);
    off  = (f == 0) ? 12 : (f == 1) ? 8 : (f == 2) ? 0 : 1;
    len  = (f == 0) ? 20 : 24;
    coff = (f == 3) ? 1 : 0;
    zbad = 0;
    sbad = 0;
    for (int c = 0; c < 4; c++) got[c] = '0;
    for (int c = 0; c < 6; c++) pbv[c] = pat(k, c);
    for (int c = 0; c < 4; c++) begin
      capv[c] = pat(k + 1, c + 2);
      cap[c]  = capv[c];
    end
    tdm = t;
    fmt = f;
    for (int i = 0; i < 2; i++) begin
      bclk = 1'b0; lrck = ~act; sdin = '0; half();
      bclk = 1'b1; half();
    end
    vcnt = 0;
    for (int p = 0; p < n; p++) begin
      slot = p / 32;
      b    = p % 32;
      bclk = 1'b0;
      lrck = (p < hi) ? act : ~act;
      for (int l = 0; l < 3; l++) begin
        ch = map_rx(t, l, slot);
        sdin[l] = 1'b0;
        if (ch >= 0 && b >= off && b < off + len) begin
          word = (len == 20) ? {4'h0, pbv[ch][23:4]} : pbv[ch];
          word = word >> (len - 1 - (b - off));
          sdin[l] = word[0];
        end
      end
      half();
      s0 = sdout;
      for (int o = 0; o < 2; o++) begin
        ch = map_tx(t, o, slot);
        if (ch >= 0 && b >= coff && b < coff + 24) got[ch][23 - (b - coff)] = s0[o];
        else if (s0[o] !== 1'b0) zbad++;
      end
      bclk = 1'b1;
      half();
      if (sdout !== s0) sbad++;
    end
    for (int c = 0; c < 6; c++) begin
      expv = (len == 20) ? {pbv[c][23:4], 4'h0} : pbv[c];
      chk(pb[c] === expv, $sformatf("%s playback ch%0d tdm=%b fmt=%0d", pb_tag(t, f, hi), c, t, f),
          32'(pb[c]), 32'(expv));
    end
    for (int c = 0; c < 4; c++)
      chk(got[c] === capv[c],
          $sformatf("%s capture ch%0d tdm=%b fmt=%0d", t[0] ? pb_tag(t, f, hi) : ((f == 3) ? "R6" : "R5"), c, t, f),
          32'(got[c]), 32'(capv[c]));
    chk(vcnt == 1, "R10 strobe count", 32'(vcnt), 32'd1);
    chk(zbad == 0, "R12 idle capture bits (R7/R8 line 1)", 32'(zbad), 32'd0);
    chk(sbad == 0, "R11 capture line moved on rising edge", 32'(sbad), 32'd0);
  endtask

  initial begin
    int k;
    logic [1:0] arr [4];
    arr = '{2'b00, 2'b01, 2'b11, 2'b10};
    rst_n = 1'b0; bclk = 1'b1; lrck = 1'b0; sdin = '0; fmt = 2'd2; tdm = 2'b00; cap = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(pb === '0 && pb_valid === 1'b0 && sdout === 2'b00, "R1 reset state",
        {pb_valid, sdout, 29'(pb[0])}, 32'd0);
    k = 0;
    foreach (arr[a])
      for (int f = 0; f < 4; f++)
        for (int j = 0; j < 2; j++) begin
          run_frame(arr[a], 2'(f), k, j);
          k++;
        end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule